// File: doc/BRIEF.md
# Pipelined No-Wait Synchronous SRAM

This block is a small synchronous static memory with a separate data-in bus, data-out bus and output-enable flag. A command is a read, a write or a deselect, and one can be accepted on every clock. Read data leaves the block two active clock edges after its address was taken in. Write data is taken in two active clock edges after its address. Because reads and writes have the same timing, the shared bus can switch between them on adjacent cycles with no idle cycle between.

On each command cycle the caller either loads a fresh address and command or steps an internal burst counter. A step repeats the previous command at the next address. The counter covers the low address bits and wraps inside its window. A suspend input freezes every register in the block, and all inputs are ignored while it is high. Byte-write enables let a write change any subset of the bytes in a word.

Top module: `nws_sram`

## Requirements
- R1: Address, command, select and byte-enable inputs are captured only at a rising clock edge where `hold` is low. That edge is called an active edge.
- R2: While `hold` is high at an edge, every input is ignored and no register changes. `rdata` and `rdata_oe` keep their values and no memory word changes.
- R3: An active edge with `burst_go` low loads a new command. If any bit of `sel` is 0, the command is a deselect: no memory access and no `rdata_oe`. After reset the held command is a deselect.
- R4: An active edge with `burst_go` high repeats the previously loaded command. The low `BURST_W` address bits are incremented by one and wrap modulo 2**`BURST_W`. The upper bits are unchanged.
- R5: A loaded command is a write when `wr_n` is 0 at the loading edge. Otherwise it is a read.
- R6: `bwe_n` bit i (active low) is sampled with the address. When 0, it lets a write change bits [i*BYTE_W +: BYTE_W] of the word. Bytes whose bit is 1 keep their old contents.
- R7: The data of a read captured at active edge k is on `rdata` after active edge k+2. `rdata_oe` is 1 exactly in the cycles that follow an edge delivering read data, and 0 after edges delivering a write or deselect.
- R8: For a write captured at active edge k, the data on `wdata` at active edge k+2 is stored.
- R9: Any mix of reads, writes and deselects may be issued on consecutive active edges, with no idle cycle, and every result stays correct.
- R10: A read issued right after a write to the same address returns the newly written bytes, even while that write is still in the pipeline.
- R11: After reset `rdata_oe` is 0 and the pipeline holds no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | Suspend: freeze all state, ignore inputs |
| burst_go | input | 1 | 1 = step burst counter, 0 = load new command |
| sel | input | 3 | Three chip selects, all must be 1 for an access |
| wr_n | input | 1 | 0 = write, 1 = read, sampled at load |
| bwe_n | input | NB | Per-byte write enables, active low |
| addr | input | AW | Word address |
| wdata | input | NB*BYTE_W | Write data, sampled two active edges after its address |
| rdata | output | NB*BYTE_W | Read data |
| rdata_oe | output | 1 | Read data valid / bus drive enable |

## Verification
A wrong burst step or a lost command shows up as a wrong word or a missing `rdata_oe`. This appears two active edges after the faulty capture, or later if the error damaged the array and a later read exposes it. A register that is not frozen by `hold` shifts every later result by one cycle, and the next cycle-by-cycle comparison catches it. Byte-enable or forwarding errors show as corrupted bytes on the first read of the affected word. The bench reads every word, directly and at random, so such errors cannot stay hidden.

// File: rtl/nws_pkg.sv
package nws_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_RD   = 2'd1,
      CMD_WR   = 2'd2
   } nws_cmd_t;
endpackage

// File: rtl/nws_cmd_stage.sv
module nws_cmd_stage
   import nws_pkg::*;
#(
   parameter int AW      = 8,
   parameter int NB      = 2,
   parameter int BURST_W = 2,
   parameter int NSEL    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  logic            burst_go,
   input  logic [NSEL-1:0] sel,
   input  logic            wr_n,
   input  logic [NB-1:0]   bwe_n,
   input  logic [AW-1:0]   addr,
   output nws_cmd_t        s1_cmd,
   output logic [NB-1:0]   s1_be,
   output logic [AW-1:0]   s1_addr
);
   logic [BURST_W-1:0] lo_next;

   assign lo_next = s1_addr[BURST_W-1:0] + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_cmd  <= CMD_IDLE;
         s1_be   <= '0;
         s1_addr <= '0;
      end else if (!hold) begin
         if (burst_go) begin
            s1_addr <= {s1_addr[AW-1:BURST_W], lo_next};
         end else begin
            s1_cmd  <= (&sel) ? (wr_n ? CMD_RD : CMD_WR) : CMD_IDLE;
            s1_be   <= ~bwe_n;
            s1_addr <= addr;
         end
      end
   end

   AST_STEP_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && burst_go) |=> ($stable(s1_cmd) && $stable(s1_be))) else $error("step changed command"); // R4
   AST_STEP_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && burst_go) |=> $stable(s1_addr[AW-1:BURST_W])) else $error("step left burst window"); // R4
   AST_DESELECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !burst_go && !(&sel)) |=> (s1_cmd == CMD_IDLE)) else $error("deselect accepted"); // R3
endmodule

// File: rtl/nws_stage.sv
module nws_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (!hold) q <= d;
   end

   AST_STAGE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(q)) else $error("stage moved while held"); // R2
endmodule

// File: rtl/nws_array.sv
module nws_array
   import nws_pkg::*;
#(
   parameter int AW     = 8,
   parameter int NB     = 2,
   parameter int BYTE_W = 9,
   localparam int DW    = NB * BYTE_W,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  nws_cmd_t      cmd,
   input  logic [NB-1:0] be,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          rdata_oe
);
   logic do_wr, do_rd;

   assign do_wr = !hold && (cmd == CMD_WR);
   assign do_rd = !hold && (cmd == CMD_RD);

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [BYTE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (do_wr && be[b]) bank[addr] <= wdata[b*BYTE_W +: BYTE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata[b*BYTE_W +: BYTE_W] <= '0;
         else if (do_rd) rdata[b*BYTE_W +: BYTE_W] <= bank[addr];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_oe <= 1'b0;
      else if (!hold) rdata_oe <= (cmd == CMD_RD);
   end
endmodule

// File: rtl/nws_sram.sv
module nws_sram
   import nws_pkg::*;
#(
   parameter int AW      = 8,
   parameter int NB      = 2,
   parameter int BYTE_W  = 9,
   parameter int BURST_W = 2,
   localparam int NSEL   = 3,
   localparam int DW     = NB * BYTE_W,
   localparam int SW     = 2 + NB + AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  logic            burst_go,
   input  logic [NSEL-1:0] sel,
   input  logic            wr_n,
   input  logic [NB-1:0]   bwe_n,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   output logic            rdata_oe
);
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("AW out of range 1..12");
   end
   if (BURST_W < 1 || BURST_W >= AW) begin : g_bad_burst
      $error("BURST_W must lie in 1..AW-1");
   end
   if (NB < 1 || BYTE_W < 1) begin : g_bad_bytes
      $error("NB and BYTE_W must be positive");
   end

   nws_cmd_t      s1_cmd, s2_cmd;
   logic [NB-1:0] s1_be, s2_be;
   logic [AW-1:0] s1_addr, s2_addr;
   logic [SW-1:0] s2_bus;

   nws_cmd_stage #(.AW(AW), .NB(NB), .BURST_W(BURST_W), .NSEL(NSEL)) i_cmd (
      .clk(clk), .rst_n(rst_n), .hold(hold), .burst_go(burst_go), .sel(sel),
      .wr_n(wr_n), .bwe_n(bwe_n), .addr(addr),
      .s1_cmd(s1_cmd), .s1_be(s1_be), .s1_addr(s1_addr)
   );

   nws_stage #(.W(SW)) i_stage (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .d({s1_cmd, s1_be, s1_addr}), .q(s2_bus)
   );

   assign s2_cmd  = nws_cmd_t'(s2_bus[SW-1 -: 2]);
   assign s2_be   = s2_bus[AW +: NB];
   assign s2_addr = s2_bus[AW-1:0];

   nws_array #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W)) i_array (
      .clk(clk), .rst_n(rst_n), .hold(hold), .cmd(s2_cmd), .be(s2_be),
      .addr(s2_addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   AST_OUT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(rdata) && $stable(rdata_oe))) else $error("outputs moved while held"); // R2
   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && s2_cmd == CMD_RD) |=> rdata_oe) else $error("read gave no enable"); // R7
   AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && s2_cmd != CMD_RD) |=> !rdata_oe) else $error("enable without read"); // R7
   AST_PIPE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold) |=> (s2_addr == $past(s1_addr) && s2_cmd == $past(s1_cmd))) else $error("pipeline slip"); // R1
endmodule

// File: tb/test_nws_sram.sv
module test_nws_sram;
   localparam int AW = 8, NB = 2, BYTE_W = 9, DW = NB * BYTE_W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hold = 1'b0, burst_go = 1'b0, wr_n = 1'b1;
   logic [2:0]    sel = 3'b000;
   logic [NB-1:0] bwe_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   int n_cmp = 0, n_bad = 0;

   always #2 clk = ~clk;

   nws_sram i_nws_sram (
      .clk(clk), .rst_n(rst_n), .hold(hold), .burst_go(burst_go), .sel(sel),
      .wr_n(wr_n), .bwe_n(bwe_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );

   // reference state
   logic [DW-1:0] mem_ref [1 << AW];
   logic          q0_v = 0, q0_wr = 0, q1_v = 0, q1_wr = 0;
   logic [NB-1:0] q0_be = 0, q1_be = 0;
   logic [AW-1:0] q0_a = 0, q1_a = 0;
   logic          exp_oe = 0;
   logic [DW-1:0] exp_d = 0;

   function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] en);
      logic [DW-1:0] r = old;
      for (int b = 0; b < NB; b++) if (en[b]) r[b*BYTE_W +: BYTE_W] = nw[b*BYTE_W +: BYTE_W];
      return r;
   endfunction

   function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a);
      return {a[AW-1:2], a[1:0] + 2'd1};
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock: drive at negedge, update model and compare after the edge
   task automatic cyc(string tag, logic h, logic go, logic [2:0] s, logic w,
                      logic [NB-1:0] be, logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      hold = h; burst_go = go; sel = s; wr_n = w; bwe_n = be; addr = a; wdata = d;
      @(posedge clk);
      #1;
      if (!h) begin
         if (q1_v && q1_wr) begin
            mem_ref[q1_a] = merge(mem_ref[q1_a], d, q1_be);
            exp_oe = 1'b0;
         end else if (q1_v) begin
            exp_oe = 1'b1;
            exp_d  = mem_ref[q1_a];
         end else exp_oe = 1'b0;
         q1_v = q0_v; q1_wr = q0_wr; q1_be = q0_be; q1_a = q0_a;
         if (go) q0_a = step_addr(q0_a);
         else begin
            q0_v = &s; q0_wr = !w; q0_be = ~be; q0_a = a;
         end
      end
      check({tag, " R7 oe"}, DW'(rdata_oe), DW'(exp_oe));
      if (exp_oe) check({tag, " data"}, rdata, exp_d);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R11 reset oe", DW'(rdata_oe), '0);
      check("R11 reset data", rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;
      // R3: steps after reset continue a deselect
      for (int i = 0; i < 3; i++) cyc("R3 step after reset", 0, 1, 3'b111, 0, '0, '0, '0);

      // R4/R5/R8: fill every word in bursts of four
      for (int k = 0; k < (1 << AW) / 4; k++)
         for (int j = 0; j < 4; j++)
            cyc("R4 fill", 0, j != 0, 3'b111, 0, '0, AW'(k * 4 + 1), DW'($urandom));
      // R4: burst read back with wrap (start at low bits 3)
      for (int j = 0; j < 6; j++) cyc("R4 wrap read", 0, j != 0, 3'b111, 1, '1, 8'h17, '0);

      // R6/R10: partial write then immediate read of same word
      cyc("R6 partial wr", 0, 0, 3'b111, 0, 2'b10, 8'h40, 18'h15555);
      cyc("R10 rd after wr", 0, 0, 3'b111, 1, '1, 8'h40, 18'h2aaaa);
      cyc("R6 wr hi", 0, 0, 3'b111, 0, 2'b01, 8'h40, 18'h0f0f0);
      cyc("R10 rd hi", 0, 0, 3'b111, 1, '1, 8'h40, 18'h3ffff);
      cyc("R2 held", 1, 0, 3'b111, 0, 2'b00, 8'h40, 18'h3ffff);
      cyc("R2 held", 1, 1, 3'b111, 0, 2'b00, 8'h41, 18'h3ffff);
      cyc("R8 data edge", 0, 0, 3'b011, 1, '1, 8'h00, 18'h12345);
      cyc("R3 deselect", 0, 0, 3'b110, 0, '0, 8'h40, 18'h3ffff);
      cyc("R3 desel step", 0, 1, 3'b111, 0, '0, 8'h40, 18'h3ffff);
      cyc("R9 read", 0, 0, 3'b111, 1, '1, 8'h40, 18'h3ffff);
      cyc("R9 drain", 0, 0, 3'b000, 1, '1, 8'h00, 18'h3ffff);
      cyc("R9 drain", 0, 0, 3'b000, 1, '1, 8'h00, 18'h3ffff);

      // R1/R2/R9: constrained random mix
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 5000; i++) begin
         logic h, go;
         logic [2:0] s;
         h  = ($urandom % 10) == 0;
         go = ($urandom % 10) < 3;
         s  = (($urandom % 8) == 0) ? 3'($urandom) : 3'b111;
         cyc("R9 random", h, go, s, 1'($urandom), 2'($urandom), 8'($urandom), 18'($urandom));
      end
      for (int i = 0; i < 3; i++) cyc("R9 drain", 0, 0, 3'b000, 1, '1, '0, '0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule